// File: doc/BRIEF.md
# Performance Counter Read Permission Checker

This block decides, within a single combinational path, whether a read of a user-visible performance counter register may go ahead. A read strobe qualifies a 12-bit register address. The address is matched against the low counter window, and in 32-bit mode also against the upper-half window. The block then takes the counter's index and looks up that index in three enable masks: one written by machine software, one by the hypervisor and one by the supervisor. It combines those bits with the current privilege level, the guest (virtualized) flag and the global counter-feature enable to produce one verdict.

The instruction decode stage uses it: a miss passes the address on to the ordinary register-existence check, and a hit supplies the verdict directly. There are no clocked elements. The block has no states, so the decision is a fixed priority chain with named outcomes. The first step checks for a window hit. Next comes the feature-enable gate, then the privilege gate, then the machine enable, and last the guest-layer enables (hypervisor first, then supervisor). The possible outcomes are allow, illegal and virtual.

Top module: `ctr_perm_check`

## Requirements
- R1: `ctr_hit` is 1 exactly when `rd_en` is 1 and either `csr_addr` is in 0xC00..0xC1F, or `xlen32` is 1 and `csr_addr` is in 0xC80..0xC9F. Whenever `ctr_hit` is 0, `verdict` is 2'b00.
- R2: `verdict` uses three encodings: 2'b00 allows the read, 2'b01 raises an illegal-instruction exception, and 2'b10 raises a virtual-instruction exception. The value 2'b11 never appears.
- R3: When there is a hit and `ctr_feat_en` is 0, the verdict is illegal at every privilege level and in either guest state.
- R4: When there is a hit, the feature is enabled and `priv` is 2'b11 (machine), the verdict is allow whatever the masks and `guest_mode` hold.
- R5: The counter index is the address minus its window base: 0 for cycle, 1 for time, 2 for instret, and N for counter N (3..31). The same index applies in the upper-half window. Only mask bit [index] affects the verdict.
- R6: When there is a hit with `priv` 2'b01 (supervisor) or 2'b00 (user) and `m_en_mask[index]` is 0, the verdict is illegal.
- R7: In supervisor mode with the machine bit set and `guest_mode` 0, the verdict is allow.
- R8: With `guest_mode` 1, `priv` supervisor or user, the machine bit set and `h_en_mask[index]` 0, the verdict is virtual.
- R9: In user mode with `guest_mode` 0 and the machine bit set, the verdict follows `s_en_mask[index]`: allow if it is 1, illegal if it is 0.
- R10: In user mode with `guest_mode` 1 and both the machine and hypervisor bits set, the verdict follows `s_en_mask[index]`: allow if it is 1, virtual if it is 0.
- R11: When there is a hit, the feature is enabled and `priv` is 2'b10 (reserved), the verdict is illegal.
- R12: When the illegal and virtual conditions both hold (guest mode, machine bit clear, hypervisor bit clear), the verdict is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csr_addr | input | 12 | Register address of the read |
| rd_en | input | 1 | Read-access strobe |
| priv | input | 2 | Privilege: 0 user, 1 supervisor, 2 reserved, 3 machine |
| guest_mode | input | 1 | Virtualization (guest) active |
| xlen32 | input | 1 | 1 when running with 32-bit registers |
| ctr_feat_en | input | 1 | Counter feature enabled |
| m_en_mask | input | 32 | Machine counter-enable mask |
| h_en_mask | input | 32 | Hypervisor counter-enable mask |
| s_en_mask | input | 32 | Supervisor counter-enable mask |
| ctr_hit | output | 1 | Address is a counter in the current mode |
| verdict | output | 2 | 00 allow, 01 illegal, 10 virtual |

## Verification
The block holds no state, so a wrong intermediate value shows up at `verdict` or `ctr_hit` in the same evaluation as the inputs that cause it. A faulty window match or index calculation appears as a verdict that follows the wrong mask bit. A fault of this kind is caught when a random mask makes the bit at the true index differ from the bit at the faulty index. For this reason the sweep visits every address at every privilege, guest state, register width and feature setting. Directed cases with a single mask bit set pin down the index directly. Further directed cases cover the priority ordering between illegal and virtual.

// File: rtl/ctr_perm_pkg.sv
package ctr_perm_pkg;

    typedef enum logic [1:0] {
        VERD_ALLOW   = 2'b00,
        VERD_ILLEGAL = 2'b01,
        VERD_VIRTUAL = 2'b10
    } verdict_e;

    localparam logic [1:0] PRIV_USER  = 2'b00;
    localparam logic [1:0] PRIV_SUPER = 2'b01;
    localparam logic [1:0] PRIV_RSVD  = 2'b10;
    localparam logic [1:0] PRIV_MACH  = 2'b11;

endpackage

// File: rtl/ctr_addr_decode.sv
module ctr_addr_decode #(
    parameter int              ADDR_W  = 12,
    parameter int              NUM_CTR = 32,
    parameter logic [11:0]     LO_BASE = 12'hC00,
    parameter logic [11:0]     HI_BASE = 12'hC80,
    localparam int             IDX_W   = $clog2(NUM_CTR)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              xlen32,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    // Windows are aligned to NUM_CTR, so the low address bits are the index.
    logic lo_win;
    logic hi_win;

    always_comb begin
        lo_win = (addr[ADDR_W-1:IDX_W] == LO_BASE[ADDR_W-1:IDX_W]);
        hi_win = (addr[ADDR_W-1:IDX_W] == HI_BASE[ADDR_W-1:IDX_W]);
        hit    = rd_en && (lo_win || (xlen32 && hi_win));
        idx    = addr[IDX_W-1:0];
    end
endmodule

// File: rtl/ctr_gate_select.sv
module ctr_gate_select #(
    parameter int  NUM_CTR = 32,
    localparam int IDX_W   = $clog2(NUM_CTR)
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic [NUM_CTR-1:0] m_mask,
    input  logic [NUM_CTR-1:0] h_mask,
    input  logic [NUM_CTR-1:0] s_mask,
    output logic               m_bit,
    output logic               h_bit,
    output logic               s_bit
);
    logic [NUM_CTR-1:0] sel;

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_sel
        assign sel[g] = (idx == IDX_W'(g));
    end

    always_comb begin
        m_bit = |(sel & m_mask);
        h_bit = |(sel & h_mask);
        s_bit = |(sel & s_mask);
    end
endmodule

// File: rtl/ctr_verdict_resolve.sv
module ctr_verdict_resolve
    import ctr_perm_pkg::*;
(
    input  logic       hit,
    input  logic       feat_en,
    input  logic [1:0] priv,
    input  logic       guest,
    input  logic       m_bit,
    input  logic       h_bit,
    input  logic       s_bit,
    output verdict_e   verdict
);
    always_comb begin
        verdict = VERD_ALLOW;
        if (hit) begin
            if (!feat_en) begin
                verdict = VERD_ILLEGAL;
            end else begin
                unique case (priv)
                    PRIV_MACH: verdict = VERD_ALLOW;
                    PRIV_RSVD: verdict = VERD_ILLEGAL;
                    PRIV_SUPER: begin
                        if (!m_bit)               verdict = VERD_ILLEGAL;
                        else if (guest && !h_bit) verdict = VERD_VIRTUAL;
                        else                      verdict = VERD_ALLOW;
                    end
                    PRIV_USER: begin
                        if (!m_bit)               verdict = VERD_ILLEGAL;
                        else if (!guest)          verdict = s_bit ? VERD_ALLOW : VERD_ILLEGAL;
                        else if (!h_bit)          verdict = VERD_VIRTUAL;
                        else if (!s_bit)          verdict = VERD_VIRTUAL;
                        else                      verdict = VERD_ALLOW;
                    end
                    default: verdict = VERD_ILLEGAL;
                endcase
            end
        end
    end
endmodule

// File: rtl/ctr_perm_check.sv
module ctr_perm_check
    import ctr_perm_pkg::*;
#(
    parameter int  ADDR_W  = 12,
    parameter int  NUM_CTR = 32,
    localparam int IDX_W   = $clog2(NUM_CTR)
) (
    input  logic [ADDR_W-1:0]  csr_addr,
    input  logic               rd_en,
    input  logic [1:0]         priv,
    input  logic               guest_mode,
    input  logic               xlen32,
    input  logic               ctr_feat_en,
    input  logic [NUM_CTR-1:0] m_en_mask,
    input  logic [NUM_CTR-1:0] h_en_mask,
    input  logic [NUM_CTR-1:0] s_en_mask,
    output logic               ctr_hit,
    output logic [1:0]         verdict
);
    logic [IDX_W-1:0] idx;
    logic             m_bit;
    logic             h_bit;
    logic             s_bit;
    verdict_e         verd_q;

    ctr_addr_decode #(
        .ADDR_W (ADDR_W),
        .NUM_CTR(NUM_CTR)
    ) u_decode (
        .addr  (csr_addr),
        .rd_en (rd_en),
        .xlen32(xlen32),
        .hit   (ctr_hit),
        .idx   (idx)
    );

    ctr_gate_select #(
        .NUM_CTR(NUM_CTR)
    ) u_select (
        .idx   (idx),
        .m_mask(m_en_mask),
        .h_mask(h_en_mask),
        .s_mask(s_en_mask),
        .m_bit (m_bit),
        .h_bit (h_bit),
        .s_bit (s_bit)
    );

    ctr_verdict_resolve u_resolve (
        .hit    (ctr_hit),
        .feat_en(ctr_feat_en),
        .priv   (priv),
        .guest  (guest_mode),
        .m_bit  (m_bit),
        .h_bit  (h_bit),
        .s_bit  (s_bit),
        .verdict(verd_q)
    );

    assign verdict = verd_q;

    // Checks across decode, select and resolve outputs.
    always_comb begin
        a_r1_miss_allow: assert (ctr_hit || verdict == 2'b00);
        a_r2_no_code3: assert (verdict != 2'b11);
        a_r3_feat_off: assert (!(ctr_hit && !ctr_feat_en) || verdict == 2'b01);
        a_r4_mach_allow: assert (!(ctr_hit && ctr_feat_en && priv == PRIV_MACH) || verdict == 2'b00);
        a_r6_mclear_illegal: assert (!(ctr_hit && ctr_feat_en && !priv[1] && !m_bit) || verdict == 2'b01);
        a_r8_virt_needs_guest: assert (verdict != 2'b10 || (guest_mode && !priv[1] && m_bit));
    end
endmodule

// File: tb/ctr_perm_check_tb.sv
module ctr_perm_check_tb;
    logic [11:0] csr_addr;
    logic        rd_en;
    logic [1:0]  priv;
    logic        guest_mode;
    logic        xlen32;
    logic        ctr_feat_en;
    logic [31:0] m_en_mask;
    logic [31:0] h_en_mask;
    logic [31:0] s_en_mask;
    logic        ctr_hit;
    logic [1:0]  verdict;

    logic clk = 1'b0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    ctr_perm_check u_dut (
        .csr_addr   (csr_addr),
        .rd_en      (rd_en),
        .priv       (priv),
        .guest_mode (guest_mode),
        .xlen32     (xlen32),
        .ctr_feat_en(ctr_feat_en),
        .m_en_mask  (m_en_mask),
        .h_en_mask  (h_en_mask),
        .s_en_mask  (s_en_mask),
        .ctr_hit    (ctr_hit),
        .verdict    (verdict)
    );

    // Reference model; tag names the deciding requirement.
    task automatic model(output logic exp_hit, output logic [1:0] exp_v, output string tag);
        int  off;
        bit  mb, hb, sb;
        exp_hit = 1'b0;
        exp_v   = 2'b00;
        tag     = "R1";
        off     = -1;
        if (rd_en && csr_addr >= 12'hC00 && csr_addr <= 12'hC1F) off = int'(csr_addr) - 'hC00;
        if (rd_en && xlen32 && csr_addr >= 12'hC80 && csr_addr <= 12'hC9F) off = int'(csr_addr) - 'hC80;
        if (off < 0) return;
        exp_hit = 1'b1;
        mb = m_en_mask[off];
        hb = h_en_mask[off];
        sb = s_en_mask[off];
        if (!ctr_feat_en) begin exp_v = 2'b01; tag = "R3"; end
        else if (priv == 2'd3) begin exp_v = 2'b00; tag = "R4"; end
        else if (priv == 2'd2) begin exp_v = 2'b01; tag = "R11"; end
        else if (!mb) begin exp_v = 2'b01; tag = (guest_mode && !hb) ? "R12" : "R6"; end
        else if (priv == 2'd1) begin
            if (guest_mode && !hb) begin exp_v = 2'b10; tag = "R8"; end
            else begin exp_v = 2'b00; tag = "R7"; end
        end else if (!guest_mode) begin exp_v = sb ? 2'b00 : 2'b01; tag = "R9"; end
        else if (!hb) begin exp_v = 2'b10; tag = "R8"; end
        else begin exp_v = sb ? 2'b00 : 2'b10; tag = "R10"; end
    endtask

    task automatic check_now(input string extra);
        logic       eh;
        logic [1:0] ev;
        string      tag;
        #1;
        model(eh, ev, tag);
        n_checks++;
        if (ctr_hit !== eh || verdict !== ev) begin
            n_fail++;
            $display("FAIL %s %s addr=%h priv=%0d g=%0b x32=%0b en=%0b: hit=%0b verdict=%0b expected hit=%0b verdict=%0b",
                     tag, extra, csr_addr, priv, guest_mode, xlen32, ctr_feat_en, ctr_hit, verdict, eh, ev);
        end
    endtask

    task automatic drive(input logic [11:0] a, input logic r, input logic [1:0] p, input logic g,
                         input logic x, input logic e, input logic [31:0] m, input logic [31:0] h,
                         input logic [31:0] s);
        @(negedge clk);
        csr_addr = a; rd_en = r; priv = p; guest_mode = g; xlen32 = x; ctr_feat_en = e;
        m_en_mask = m; h_en_mask = h; s_en_mask = s;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        csr_addr = '0; rd_en = 1'b0; priv = 2'd0; guest_mode = 1'b0; xlen32 = 1'b0;
        ctr_feat_en = 1'b0; m_en_mask = '0; h_en_mask = '0; s_en_mask = '0;

        // R1 idle state: no read strobe gives no hit and allow
        drive(12'hC00, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 32'h0);
        check_now("R1 idle");

        // R1 addresses outside the windows, and upper window in 64-bit mode
        drive(12'hC20, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 32'h0); check_now("R1 above lo");
        drive(12'hBFF, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 32'h0); check_now("R1 below lo");
        drive(12'hCA0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 32'h0); check_now("R1 above hi");
        drive(12'hC85, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0); check_now("R1 hi in rv64");

        // R5 single-bit masks pin the index: counter 5 maps to bit 5, not bit 2
        drive(12'hC05, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 32'h20, 32'h0, 32'h0); check_now("R5 idx5 lo");
        drive(12'hC02, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 32'h20, 32'h0, 32'h0); check_now("R5 idx2 lo");
        drive(12'hC85, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 32'h20, 32'h0, 32'h0); check_now("R5 idx5 hi");
        drive(12'hC9F, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 32'h8000_0000, 32'h0, 32'h0); check_now("R5 idx31 hi");

        // R12 priority, R10 guest user, R9 plain user
        drive(12'hC03, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 32'h0, 32'h0, 32'hFFFF_FFFF); check_now("R12 both");
        drive(12'hC03, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 32'h8, 32'h8, 32'h0); check_now("R10 s clear");
        drive(12'hC03, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 32'h8, 32'h0, 32'h0); check_now("R9 s clear");
        drive(12'hC01, 1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 32'h0, 32'h0, 32'h0); check_now("R4 mach zero masks");
        drive(12'hC01, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF); check_now("R11 rsvd");

        // Full sweep: every counter address, privilege, guest, width, feature; random masks.
        // Covers R2 R3 R4 R6 R7 R8 R9 R10 R11 R12 via the model tags.
        for (int pass = 0; pass < 3; pass++) begin
            for (int a = 0; a < 64; a++) begin
                for (int p = 0; p < 4; p++) begin
                    for (int g = 0; g < 2; g++) begin
                        for (int x = 0; x < 2; x++) begin
                            for (int e = 0; e < 2; e++) begin
                                drive((a < 32) ? 12'(12'hC00 + a) : 12'(12'hC80 + a - 32), 1'b1,
                                      2'(p), 1'(g), 1'(x), 1'(e),
                                      $urandom, $urandom, $urandom);
                                check_now("sweep");
                            end
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule